// File: doc/BRIEF.md
# Byte-Wide Sampling Converter Read Sequencer

This block sits on the host side of a 12-bit successive-approximation converter whose data leaves on an 8-bit bus. A single-cycle request makes it select the converter, pulse the active-low conversion start, and follow the converter's ready line through the whole conversion. It then fetches the result in two reads: the low byte first, with the byte-select line low, and then the upper nibble, with the byte-select line high. The two halves are joined into one 12-bit word, which is presented with a one-cycle valid strobe.

Every interface interval is a parameter counted in clock cycles. These intervals are the select-to-start setup, the start pulse width, the read strobe width, the byte-select setup and hold around each strobe, and the acquisition gap between conversions. The start pulse is released well before the first bit decision, so it never lands on one. The upper four lanes of the high-byte read must be zero, and a format-error flag reports any other value. If the converter never signals a conversion, a timeout ends the attempt with an abort strobe. A request that arrives while a transaction is running is remembered, and is served once the gap has passed.

Top module: `adc_byte_reader`

## Requirements
- R1: During and after reset, with no request, chip select, start and read strobe are high (inactive), byte select is low, and valid and abort are low.
- R2: Chip select is driven low exactly CS_SETUP_CYC cycles before start falls. It stays low through both reads, and it rises once per completed transaction.
- R3: The start pulse is low for exactly START_LOW_CYC cycles and is released without waiting for the ready line.
- R4: No read strobe is issued while the ready input is low, and a completed transaction issues exactly two read strobes.
- R5: The first read has byte select low and the second has it high. Byte select is stable for at least HB_SETUP_CYC cycles before each strobe falls and for at least HB_HOLD_CYC cycles after it rises.
- R6: Each read strobe is low for exactly RD_LOW_CYC cycles, and the bus is sampled on its last low cycle.
- R7: The result equals {high byte bits 3..0, low byte bits 7..0}. The valid output is a single-cycle pulse.
- R8: The format-error output is set with valid when bits 7..4 of the high-byte read are non-zero, and is clear otherwise.
- R9: If the ready input has not fallen within BUSY_TMO_CYC cycles of start rising, abort pulses for one cycle with chip select already high. No read and no valid follow, and the next request converts normally.
- R10: After each transaction chip select stays high for at least GAP_CYC cycles. The next start falls no sooner than GAP_CYC cycles after ready rose.
- R11: Requests that arrive during a transaction collapse into one pending request, which starts exactly one further conversion after the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Conversion request, one cycle |
| adc_ready | input | 1 | Converter ready line, low while converting |
| adc_d | input | BUS_W | Converter data bus |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_start_n | output | 1 | Conversion start, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_hisel | output | 1 | Byte select: high picks the upper nibble |
| res_data | output | RES_W | Assembled result |
| res_valid | output | 1 | Result strobe |
| res_fmt_err | output | 1 | Upper lanes of the high-byte read were non-zero |
| res_abort | output | 1 | Conversion never began; attempt aborted |

## Verification
The pending-request path is the hardest case to reach. Requests must arrive while the first conversion is still in flight, and several of them must be folded into exactly one extra conversion. The bench gets there by issuing two further requests after the first start falls, while the converter model holds ready low. It then counts start pulses over a long idle tail. The timeout path needs a converter that ignores the start pulse, which a switch in the model provides. The format-error case uses a model that drives non-zero upper lanes during the high-byte read.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP_CS, S_START_LOW, S_WAIT_BUSY_LOW,
    S_WAIT_BUSY_HIGH, S_READ_LO, S_READ_HI, S_GAP
  } rd_state_e;

  typedef enum logic [1:0] {
    PH_SETUP, PH_STROBE, PH_HOLD
  } rd_phase_e;

  function automatic int cmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/adc_rd_assemble.sv
module adc_rd_assemble #(
  parameter int BUS_W = 8,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_lo,
  input  logic             cap_hi,
  input  logic [BUS_W-1:0] bus,
  output logic [RES_W-1:0] data,
  output logic             valid,
  output logic             fmt_err
);

  localparam int HW = RES_W - BUS_W;

  logic [BUS_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      data    <= '0;
      valid   <= 1'b0;
      fmt_err <= 1'b0;
    end else begin
      valid <= cap_hi;
      if (cap_lo) lo_q <= bus;
      if (cap_hi) begin
        data    <= {bus[HW-1:0], lo_q};
        fmt_err <= |bus[BUS_W-1:HW];
      end
    end
  end

  // R7: two high-byte captures never come back to back
  p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

endmodule

// File: rtl/adc_byte_reader.sv
module adc_byte_reader
  import adc_rd_pkg::*;
#(
  parameter int BUS_W         = 8,
  parameter int RES_W         = 12,
  parameter int CS_SETUP_CYC  = 8,
  parameter int START_LOW_CYC = 12,
  parameter int BUSY_TMO_CYC  = 64,
  parameter int HB_SETUP_CYC  = 3,
  parameter int RD_LOW_CYC    = 48,
  parameter int HB_HOLD_CYC   = 3,
  parameter int GAP_CYC       = 500
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             adc_ready,
  input  logic [BUS_W-1:0] adc_d,
  output logic             adc_cs_n,
  output logic             adc_start_n,
  output logic             adc_rd_n,
  output logic             adc_hisel,
  output logic [RES_W-1:0] res_data,
  output logic             res_valid,
  output logic             res_fmt_err,
  output logic             res_abort
);

  localparam int MAXC = cmax(cmax(cmax(CS_SETUP_CYC, START_LOW_CYC),
                                  cmax(BUSY_TMO_CYC, HB_SETUP_CYC)),
                             cmax(cmax(RD_LOW_CYC, HB_HOLD_CYC), GAP_CYC));
  localparam int TW = $clog2(MAXC + 1);

  localparam logic [TW-1:0] L_CS   = TW'(CS_SETUP_CYC - 1);
  localparam logic [TW-1:0] L_ST   = TW'(START_LOW_CYC - 1);
  localparam logic [TW-1:0] L_TMO  = TW'(BUSY_TMO_CYC - 1);
  localparam logic [TW-1:0] L_HS   = TW'(HB_SETUP_CYC - 1);
  localparam logic [TW-1:0] L_RD   = TW'(RD_LOW_CYC - 1);
  localparam logic [TW-1:0] L_HH   = TW'(HB_HOLD_CYC - 1);
  localparam logic [TW-1:0] L_GAP  = TW'(GAP_CYC - 1);

  rd_state_e st, st_d;
  rd_phase_e ph, ph_d;
  logic          ld, tz, take, abort_d, pend;
  logic [TW-1:0] ldv;
  logic          cap_lo, cap_hi;

  adc_rd_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(ld), .load_val(ldv), .zero(tz)
  );

  always_comb begin
    st_d = st; ph_d = ph; ld = 1'b0; ldv = '0; abort_d = 1'b0; take = 1'b0;
    case (st)
      S_IDLE:
        if (req || pend) begin
          st_d = S_SETUP_CS; ld = 1'b1; ldv = L_CS; take = 1'b1;
        end
      S_SETUP_CS:
        if (tz) begin st_d = S_START_LOW; ld = 1'b1; ldv = L_ST; end
      S_START_LOW:
        if (tz) begin st_d = S_WAIT_BUSY_LOW; ld = 1'b1; ldv = L_TMO; end
      S_WAIT_BUSY_LOW:
        if (!adc_ready) st_d = S_WAIT_BUSY_HIGH;
        else if (tz) begin
          st_d = S_GAP; ld = 1'b1; ldv = L_GAP; abort_d = 1'b1;
        end
      S_WAIT_BUSY_HIGH:
        if (adc_ready) begin
          st_d = S_READ_LO; ph_d = PH_SETUP; ld = 1'b1; ldv = L_HS;
        end
      S_READ_LO, S_READ_HI:
        if (tz) begin
          ld = 1'b1;
          case (ph)
            PH_SETUP:  begin ph_d = PH_STROBE; ldv = L_RD; end
            PH_STROBE: begin ph_d = PH_HOLD;   ldv = L_HH; end
            default:
              if (st == S_READ_LO) begin
                st_d = S_READ_HI; ph_d = PH_SETUP; ldv = L_HS;
              end else begin
                st_d = S_GAP; ph_d = PH_SETUP; ldv = L_GAP;
              end
          endcase
        end
      default:
        if (tz) begin
          if (req || pend) begin
            st_d = S_SETUP_CS; ld = 1'b1; ldv = L_CS; take = 1'b1;
          end else st_d = S_IDLE;
        end
    endcase
  end

  assign cap_lo = (st == S_READ_LO) && (ph == PH_STROBE) && tz;
  assign cap_hi = (st == S_READ_HI) && (ph == PH_STROBE) && tz;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      ph          <= PH_SETUP;
      pend        <= 1'b0;
      adc_cs_n    <= 1'b1;
      adc_start_n <= 1'b1;
      adc_rd_n    <= 1'b1;
      adc_hisel   <= 1'b0;
      res_abort   <= 1'b0;
    end else begin
      st <= st_d;
      ph <= ph_d;
      if (take)                    pend <= 1'b0;
      else if (req && st != S_IDLE) pend <= 1'b1;
      adc_cs_n    <= (st_d == S_IDLE) || (st_d == S_GAP);
      adc_start_n <= (st_d != S_START_LOW);
      adc_rd_n    <= !(((st_d == S_READ_LO) || (st_d == S_READ_HI)) &&
                       (ph_d == PH_STROBE));
      adc_hisel   <= (st_d == S_READ_HI);
      res_abort   <= abort_d;
    end
  end

  adc_rd_assemble #(.BUS_W(BUS_W), .RES_W(RES_W)) u_asm (
    .clk(clk), .rst(rst), .cap_lo(cap_lo), .cap_hi(cap_hi), .bus(adc_d),
    .data(res_data), .valid(res_valid), .fmt_err(res_fmt_err)
  );

  p_start_in_cs_r2: assert property (@(posedge clk) disable iff (rst)
    !adc_start_n |-> !adc_cs_n);

  p_read_in_cs_r6: assert property (@(posedge clk) disable iff (rst)
    !adc_rd_n |-> (!adc_cs_n && adc_start_n));

  p_hisel_setup_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_rd_n) |-> $stable(adc_hisel));

  p_hisel_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_rd_n) |-> $stable(adc_hisel));

  p_abort_clean_r9: assert property (@(posedge clk) disable iff (rst)
    res_abort |-> (adc_cs_n && !res_valid && adc_rd_n));

  p_no_idle_pending_r11: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE) |-> !pend);

endmodule

// File: tb/adc_byte_reader_test.sv
module adc_byte_reader_test;

  localparam int BUS_W = 8, RES_W = 12;
  localparam int CS_SETUP = 8, START_LOW = 12, BUSY_TMO = 64;
  localparam int HB_SETUP = 3, RD_LOW = 48, HB_HOLD = 3, GAP = 500;
  localparam int BUSY_DLY = 10, CONV = 200;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, req = 1'b0, adc_ready = 1'b1;
  logic mdl_en = 1'b1;
  logic [11:0] mdl_val = '0;
  logic [3:0]  mdl_top = '0;
  logic [BUS_W-1:0] adc_d;
  logic adc_cs_n, adc_start_n, adc_rd_n, adc_hisel;
  logic [RES_W-1:0] res_data;
  logic res_valid, res_fmt_err, res_abort;

  assign adc_d = (!adc_cs_n && !adc_rd_n) ?
                 (adc_hisel ? {mdl_top, mdl_val[11:8]} : mdl_val[7:0]) : 8'h00;

  adc_byte_reader #(
    .BUS_W(BUS_W), .RES_W(RES_W), .CS_SETUP_CYC(CS_SETUP),
    .START_LOW_CYC(START_LOW), .BUSY_TMO_CYC(BUSY_TMO),
    .HB_SETUP_CYC(HB_SETUP), .RD_LOW_CYC(RD_LOW), .HB_HOLD_CYC(HB_HOLD),
    .GAP_CYC(GAP)
  ) uut (
    .clk(clk), .rst(rst), .req(req), .adc_ready(adc_ready), .adc_d(adc_d),
    .adc_cs_n(adc_cs_n), .adc_start_n(adc_start_n), .adc_rd_n(adc_rd_n),
    .adc_hisel(adc_hisel), .res_data(res_data), .res_valid(res_valid),
    .res_fmt_err(res_fmt_err), .res_abort(res_abort)
  );

  // converter model
  always begin
    @(negedge adc_start_n);
    if (!adc_cs_n && mdl_en) begin
      repeat (BUSY_DLY) @(posedge clk);
      #1 adc_ready = 1'b0;
      repeat (CONV) @(posedge clk);
      #1 adc_ready = 1'b1;
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor, sampled on the falling edge
  int cyc = 0, cs_low_cnt = 0, cs_high_cnt = 0, last_cs_high = 0;
  int st_low_cnt = 0, last_st_low = 0, last_cs_setup = 0, starts = 0;
  int rd_falls = 0, txn_rd = 0, rd_busy_viol = 0, rd_nocs = 0;
  int rd_low_cnt = 0, rd_len_min = 0, rd_len_max = 0;
  int hi_age = 0, setup_min = 0, since_rise = 0, hold_min = 0;
  int valids = 0, vld_wide = 0, aborts = 0, abort_cs_bad = 0, cs_rises = 0;
  int rdy_rise_cyc = 0, last_gap = 0, st_rise_cyc = 0, abort_cyc = 0;
  bit seen_rdy = 0, trk_hold = 0, hi_first = 0, hi_second = 0;
  logic [11:0] got_data = '0;
  bit got_fmt = 0;
  logic p_cs = 1, p_st = 1, p_rd = 1, p_hi = 0, p_rdy = 1, p_vld = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_cs && !adc_cs_n) begin
        last_cs_high = cs_high_cnt;
        rd_len_min = 1 << 30; rd_len_max = 0; setup_min = 1 << 30;
        hold_min = 1 << 30; txn_rd = 0; rd_busy_viol = 0; rd_nocs = 0;
      end
      if (!p_cs && adc_cs_n) cs_rises++;
      if (p_st && !adc_start_n) begin
        starts++; last_cs_setup = cs_low_cnt;
        if (seen_rdy) last_gap = cyc - rdy_rise_cyc;
      end
      if (!p_st && adc_start_n) begin last_st_low = st_low_cnt; st_rise_cyc = cyc; end
      if (!p_rdy && adc_ready) begin rdy_rise_cyc = cyc; seen_rdy = 1; end
      if (!adc_rd_n && adc_cs_n) rd_nocs++;
      if (p_rd && !adc_rd_n) begin
        rd_falls++; txn_rd++;
        if (!adc_ready) rd_busy_viol++;
        if (txn_rd == 1) hi_first = adc_hisel; else hi_second = adc_hisel;
        if (((adc_hisel == p_hi) ? hi_age : 0) < setup_min)
          setup_min = (adc_hisel == p_hi) ? hi_age : 0;
      end
      if (!p_rd && adc_rd_n) begin
        if (rd_low_cnt < rd_len_min) rd_len_min = rd_low_cnt;
        if (rd_low_cnt > rd_len_max) rd_len_max = rd_low_cnt;
        trk_hold = 1; since_rise = 0;
      end
      if (trk_hold) begin
        if (adc_hisel != p_hi) begin
          if (since_rise < hold_min) hold_min = since_rise;
          trk_hold = 0;
        end else since_rise++;
      end
      if (res_valid) begin
        valids++; got_data = res_data; got_fmt = res_fmt_err;
        if (p_vld) vld_wide++;
      end
      if (res_abort) begin
        aborts++; abort_cyc = cyc;
        if (!adc_cs_n) abort_cs_bad++;
      end
    end
    cs_low_cnt  = adc_cs_n ? 0 : cs_low_cnt + 1;
    cs_high_cnt = adc_cs_n ? cs_high_cnt + 1 : 0;
    st_low_cnt  = adc_start_n ? 0 : st_low_cnt + 1;
    rd_low_cnt  = adc_rd_n ? 0 : rd_low_cnt + 1;
    hi_age      = (adc_hisel == p_hi) ? hi_age + 1 : 1;
    p_cs = adc_cs_n; p_st = adc_start_n; p_rd = adc_rd_n;
    p_hi = adc_hisel; p_rdy = adc_ready; p_vld = res_valid;
  end

  task automatic pulse_req();
    @(posedge clk); #1 req = 1'b1;
    @(posedge clk); #1 req = 1'b0;
  endtask

  task automatic wait_valids(input int target, input int lim);
    for (int i = 0; i < lim && valids < target; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(adc_cs_n && adc_start_n && adc_rd_n && !adc_hisel, "R1 strobes in reset",
        {adc_cs_n, adc_start_n, adc_rd_n, adc_hisel}, 4'b1110);
    #1 rst = 1'b0;
    repeat (30) @(negedge clk);
    chk(adc_cs_n && adc_start_n && adc_rd_n && !adc_hisel && !res_valid && !res_abort,
        "R1 idle after reset",
        {adc_cs_n, adc_start_n, adc_rd_n, adc_hisel, res_valid, res_abort}, 6'b111000);
    chk(starts == 0, "R1 no start without request", starts, 0);
  endtask

  task automatic t_convert(input logic [11:0] val, input logic [3:0] top);
    int v0, r0, c0;
    v0 = valids; r0 = rd_falls; c0 = cs_rises;
    mdl_val = val; mdl_top = top;
    pulse_req();
    wait_valids(v0 + 1, 3000);
    repeat (GAP + 20) @(negedge clk);
    chk(valids == v0 + 1, "R7 one valid", valids - v0, 1);
    chk(got_data == {val[11:8], val[7:0]}, "R7 result", got_data, val);
    chk(vld_wide == 0, "R7 valid width", vld_wide, 0);
    chk(got_fmt == (top != 4'h0), "R8 format flag", got_fmt, top != 4'h0);
    chk(last_cs_setup == CS_SETUP, "R2 select setup", last_cs_setup, CS_SETUP);
    chk(cs_rises == c0 + 1 && rd_nocs == 0, "R2 select held", cs_rises - c0, 1);
    chk(last_st_low == START_LOW, "R3 start width", last_st_low, START_LOW);
    chk(rd_falls == r0 + 2 && rd_busy_viol == 0, "R4 reads after ready",
        rd_falls - r0, 2);
    chk(!hi_first && hi_second, "R5 byte order", {hi_first, hi_second}, 2'b01);
    chk(setup_min >= HB_SETUP, "R5 select setup", setup_min, HB_SETUP);
    chk(hold_min >= HB_HOLD, "R5 select hold", hold_min, HB_HOLD);
    chk(rd_len_min == RD_LOW && rd_len_max == RD_LOW, "R6 strobe width",
        rd_len_min, RD_LOW);
  endtask

  task automatic t_timeout();
    int v0, r0, a0;
    v0 = valids; r0 = rd_falls; a0 = aborts;
    mdl_en = 1'b0;
    pulse_req();
    for (int i = 0; i < 500 && aborts == a0; i++) @(negedge clk);
    repeat (GAP + 20) @(negedge clk);
    mdl_en = 1'b1;
    chk(aborts == a0 + 1, "R9 abort pulse", aborts - a0, 1);
    chk(abort_cyc - st_rise_cyc == BUSY_TMO, "R9 abort timing",
        abort_cyc - st_rise_cyc, BUSY_TMO);
    chk(abort_cs_bad == 0, "R9 select released", abort_cs_bad, 0);
    chk(rd_falls == r0 && valids == v0, "R9 no read or valid",
        rd_falls - r0 + valids - v0, 0);
    t_convert(12'h6B2, 4'h0);  // R9 recovery
  endtask

  task automatic t_pending();
    int v0, s0;
    v0 = valids; s0 = starts;
    mdl_val = 12'h9E4; mdl_top = 4'h0;
    pulse_req();
    for (int i = 0; i < 200 && starts == s0; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    pulse_req();
    repeat (30) @(negedge clk);
    pulse_req();
    wait_valids(v0 + 2, 5000);
    repeat (1500) @(negedge clk);
    chk(starts == s0 + 2, "R11 one extra conversion", starts - s0, 2);
    chk(valids == v0 + 2, "R11 two results", valids - v0, 2);
    chk(got_data == 12'h9E4, "R11 second result", got_data, 12'h9E4);
    chk(last_cs_high >= GAP, "R10 select gap", last_cs_high, GAP);
    chk(last_gap >= GAP, "R10 ready to start gap", last_gap, GAP);
  endtask

  bit done = 0;

  initial begin
    t_reset();
    t_convert(12'hA5C, 4'h0);
    t_convert(12'h000, 4'h0);
    t_convert(12'hFFF, 4'h0);
    t_convert(12'h5A3, 4'hC);   // R8 set
    t_convert(12'h3C1, 4'h0);   // R8 clears
    t_timeout();
    t_pending();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule